// File: doc/BRIEF.md
# Six-Channel Shadowed PWM Generator

This block drives six independent pulse-width outputs from one clock. Software programs each channel through a small word-addressed register file: a 3-bit clock divider, a 24-bit period count, a 24-bit high-time count and an output polarity bit. Every write lands in a shadow copy only. The running waveform takes the new settings only after that channel's trigger bit goes from 0 to 1.

At that rising edge the channel's smooth bit picks the switch-over mode. With smooth set, the current period finishes untouched and the new settings start at the next period boundary. With smooth clear, the new settings start after a fixed delay of `APPLY_DLY` clock cycles, and the counters restart at the beginning of a period.

There is no enable bit. Software turns a channel off by applying a zero high-time. Clearing both trigger and smooth for a channel forces its output high. The usual update sequence is: set smooth and clear trigger, write the shadows, then raise trigger.

Top module: `pwm_bank`

## Requirements
- R1: After reset every bit of `pwm_out` is 1 and every register reads back as zero.
- R2: Register map, byte addresses:
  - 0x00 is the control word. For channel c, bit c is the trigger, bit 8+c is the polarity, bit 16+c is the output type (stored only) and bit 24+c is smooth.
  - 0x04 holds the 3-bit divider of channel c at bits 4c+2..4c.
  - 0x08+8c is the period count and 0x0C+8c is the high-time count. Only the low 24 bits of these two are kept.
  - Every register reads back the value last written to it.
- R3: With polarity 1 and divider p, period count N ≥ 2 and high-time D with 0 < D < N, the output is high for (p+1)·D cycles and low for (p+1)·(N−D) cycles in each period.
- R4: With polarity 0, the output level is inverted after the high-time comparison: low for (p+1)·D cycles and high for (p+1)·(N−D) cycles.
- R5: Writes to divider, period, high-time and polarity do not change the running waveform until that channel's trigger bit rises. This includes writes made while the trigger bit is held at 1, and changing smooth from 0 to 1 while trigger stays 1 or 0.
- R6: A trigger rise with smooth 0 applies the new settings so that the output shows them exactly `APPLY_DLY`+2 cycles after the clock edge that accepts the control write. The new waveform starts at the beginning of a period, with its active phase first.
- R7: A trigger rise with smooth 1 lets the current period run to its end with the old settings. The new settings take effect from the next period.
- R8: A channel whose trigger and smooth bits are both 0 outputs a constant 1.
- R9: A high-time of 0 gives a constant inactive level (the inverse of polarity). A high-time ≥ the period count gives a constant active level (equal to polarity).
- R10: A period count below 2 holds the output at the inactive level.
- R11: Programming or triggering one channel leaves the waveforms of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and the counters |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe; the write takes effect at the rising clock edge |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | DATA_W | Read data, combinational from `rd_addr` |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench counts the cycles from the trigger write to the first changed output level. A design that applied settings on the trigger level instead of its edge, or used the wrong delay, would miss the exact `APPLY_DLY`+2 count. For smooth mode it triggers early in a long high phase and measures the low phase that follows. A design that switched at once would cut that low phase short, where the correct design keeps the full old length. It also rewrites shadows while trigger stays high, clears both control bits, and applies zero, over-long and sub-minimum counts. A leaky shadow path, a missing forced-high state, or a wrong edge case in the comparator would each show up as the wrong constant level or the wrong pulse length.

// File: rtl/pwm_bank_pkg.sv
// pwm_bank_pkg: widths, register layout and the per-channel settings record
// shared by the register file and the channel engines.
// Assumes at most 8 channels, so that each per-channel control bit fits its byte lane.
package pwm_bank_pkg;

    localparam int CNT_W         = 24;  // period / high-time counter width
    localparam int PRE_W         = 3;   // divider field width
    localparam int CTRL_OFS      = 0;   // control word address
    localparam int PRE_OFS       = 4;   // divider word address
    localparam int PER_BASE      = 8;   // period count of channel 0
    localparam int HIGH_BASE     = 12;  // high-time count of channel 0
    localparam int CH_STRIDE     = 8;   // address step between channels
    localparam int PRE_LANE      = 4;   // bit step between divider fields
    localparam int POL_BIT0      = 8;   // polarity bit of channel 0
    localparam int SMOOTH_BIT0   = 24;  // smooth bit of channel 0

    // Settings of one channel, shadow or active.
    typedef struct packed {
        logic             pol;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] high;
    } chan_cfg_t;

endpackage

// File: rtl/pwm_bank_regs.sv
// pwm_bank_regs: holds the software-visible shadow registers and decodes
// word writes and combinational reads.
// Assumes word-aligned byte addresses and NUM_CH <= 8.
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output chan_cfg_t         shadow [NUM_CH],
    output logic [NUM_CH-1:0] trig,
    output logic [NUM_CH-1:0] smooth
);

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] pre_q;
    logic [CNT_W-1:0]  per_q  [NUM_CH];
    logic [CNT_W-1:0]  high_q [NUM_CH];

    // Register write decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pre_q  <= '0;
            for (int c = 0; c < NUM_CH; c++) begin
                per_q[c]  <= '0;
                high_q[c] <= '0;
            end
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(CTRL_OFS)) ctrl_q <= wr_data;
            if (wr_addr == ADDR_W'(PRE_OFS))  pre_q  <= wr_data;
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_addr == ADDR_W'(PER_BASE + CH_STRIDE * c))
                    per_q[c] <= wr_data[CNT_W-1:0];
                if (wr_addr == ADDR_W'(HIGH_BASE + CH_STRIDE * c))
                    high_q[c] <= wr_data[CNT_W-1:0];
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(CTRL_OFS)) rd_data = ctrl_q;
        if (rd_addr == ADDR_W'(PRE_OFS))  rd_data = pre_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == ADDR_W'(PER_BASE + CH_STRIDE * c))
                rd_data = DATA_W'(per_q[c]);
            if (rd_addr == ADDR_W'(HIGH_BASE + CH_STRIDE * c))
                rd_data = DATA_W'(high_q[c]);
        end
    end

    // Fan the fields out to the channel engines.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_fan
        assign shadow[g].pol    = ctrl_q[POL_BIT0 + g];
        assign shadow[g].pre    = pre_q[PRE_LANE * g +: PRE_W];
        assign shadow[g].period = per_q[g];
        assign shadow[g].high   = high_q[g];
        assign trig[g]          = ctrl_q[g];
        assign smooth[g]        = ctrl_q[SMOOTH_BIT0 + g];
    end

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CTRL_OFS)) |=> (ctrl_q == $past(wr_data))); // R2

endmodule

// File: rtl/pwm_bank_chan.sv
// pwm_bank_chan: one PWM channel. It detects the trigger rising edge, moves
// the shadow settings into the active set (at once after a delay, or at a
// period boundary), runs the divided counters and drives the polarised output.
// Assumes APPLY_DLY >= 1. The shadow is sampled at the moment of transfer.
module pwm_bank_chan
    import pwm_bank_pkg::*;
#(
    parameter int APPLY_DLY = 20
) (
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t shadow,
    input  logic      trig_i,
    input  logic      smooth_i,
    output logic      pwm_o
);

    localparam int DLY_W = $clog2(APPLY_DLY + 1);

    logic             trig_d;
    logic             trig_rise;
    logic             pend_imm;
    logic             pend_smooth;
    logic [DLY_W-1:0] dly_q;
    chan_cfg_t        act_q;
    logic [PRE_W-1:0] pre_cnt;
    logic [CNT_W-1:0] per_cnt;
    logic             tick;
    logic             at_end;
    logic             boundary;
    logic             load_imm;
    logic             load_smooth;
    logic             active;
    logic             level;

    assign trig_rise   = trig_i & ~trig_d;
    assign tick        = (pre_cnt == act_q.pre);
    assign at_end      = (act_q.period < CNT_W'(2)) || (per_cnt == act_q.period - CNT_W'(1));
    assign boundary    = tick & at_end;
    assign load_imm    = pend_imm & (dly_q == '0) & ~trig_rise;
    assign load_smooth = pend_smooth & boundary & ~trig_rise;
    assign active      = (act_q.period >= CNT_W'(2)) && (per_cnt < act_q.high);
    assign level       = act_q.pol ? active : ~active;

    // Delayed trigger for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_d <= 1'b0;
        else        trig_d <= trig_i;
    end

    // Pending-transfer state and the immediate-mode delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_imm    <= 1'b0;
            pend_smooth <= 1'b0;
            dly_q       <= '0;
        end else if (trig_rise) begin
            pend_imm    <= ~smooth_i;
            pend_smooth <= smooth_i;
            dly_q       <= DLY_W'(APPLY_DLY - 1);
        end else begin
            if (load_imm)      pend_imm <= 1'b0;
            else if (pend_imm) dly_q    <= dly_q - DLY_W'(1);
            if (load_smooth)   pend_smooth <= 1'b0;
        end
    end

    // Active settings, copied from the shadow on a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                        act_q <= '0;
        else if (load_imm || load_smooth)  act_q <= shadow;
    end

    // Divider and period counters; an immediate transfer restarts both.
    always_ff @(posedge clk) begin
        if (!rst_n || load_imm) begin
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
            per_cnt <= at_end ? '0 : per_cnt + CNT_W'(1);
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    // Registered output with the forced-high state.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pwm_o <= 1'b1;
        else if (!trig_i && !smooth_i) pwm_o <= 1'b1;
        else                          pwm_o <= level;
    end

    AST_FORCED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_i && !smooth_i) |=> pwm_o); // R8
    AST_SHADOW_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_rise && !pend_imm && !pend_smooth) |=> $stable(act_q)); // R5
    AST_DELAY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pend_imm |-> (dly_q < DLY_W'(APPLY_DLY))); // R6
    AST_SMOOTH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_smooth && !boundary && !trig_rise) |=> (pend_smooth && $stable(act_q))); // R7
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.period >= CNT_W'(2)) |-> (per_cnt < act_q.period)); // R3
    AST_ZERO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.high == '0 && (trig_i || smooth_i) && !load_imm && !load_smooth)
        |=> (pwm_o == !$past(act_q.pol))); // R9

endmodule

// File: rtl/pwm_bank.sv
// pwm_bank: top level. One shared register file feeds NUM_CH independent
// channel engines.
// Assumes NUM_CH <= 8 and ADDR_W wide enough for the last high-time register.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH    = 6,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter int APPLY_DLY = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] pwm_out
);

    chan_cfg_t         shadow [NUM_CH];
    logic [NUM_CH-1:0] trig;
    logic [NUM_CH-1:0] smooth;

    pwm_bank_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .shadow  (shadow),
        .trig    (trig),
        .smooth  (smooth)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pwm_bank_chan #(
            .APPLY_DLY (APPLY_DLY)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .shadow   (shadow[g]),
            .trig_i   (trig[g]),
            .smooth_i (smooth[g]),
            .pwm_o    (pwm_out[g])
        );
    end

endmodule

// File: tb/pwm_bank_bench.sv
// pwm_bank_bench: scoreboard bench. Driver tasks program channels and push
// expected waveform items; a monitor process measures pwm_out and compares.
module pwm_bank_bench;

    localparam int LAT = 20;

    typedef struct {
        string req;
        int    ch;
        int    kind;  // 0: high/low lengths, 1: constant level, 2: next low run
        int    a;
        int    b;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [5:0]  pwm_out;

    int          n_tests = 0;
    int          n_fail  = 0;
    item_t       sb_q[$];
    logic [31:0] ctrl_v = '0;
    logic [31:0] pre_v  = '0;

    always #5 clk = ~clk;

    pwm_bank #(.APPLY_DLY(LAT)) u_pwm_bank (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[5:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a[5:0];
        #1 d = rd_data;
    endtask

    // Prepare (smooth=1, trigger=0), write the shadows, then raise the trigger.
    task automatic cfg_ch(input int ch, input int pre, input int per, input int hi,
                          input bit pol, input bit smooth_mode);
        ctrl_v[24 + ch] = 1'b1; ctrl_v[ch] = 1'b0;
        wr(0, ctrl_v);
        pre_v[4*ch +: 3] = pre[2:0];
        wr(4, pre_v);
        wr(8 + 8*ch, per);
        wr(12 + 8*ch, hi);
        ctrl_v[8 + ch] = pol;
        ctrl_v[ch] = 1'b1; ctrl_v[24 + ch] = smooth_mode;
        wr(0, ctrl_v);
    endtask

    task automatic settle();
        repeat (LAT + 4) @(negedge clk);
    endtask

    task automatic push(input string req, input int ch, input int kind, input int a, input int b);
        item_t it;
        it.req = req; it.ch = ch; it.kind = kind; it.a = a; it.b = b;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
    endtask

    // Monitor: pop each expected item, measure the output, compare.
    initial begin
        forever begin
            item_t it;
            int    hi;
            int    lo;
            wait (sb_q.size() > 0);
            it = sb_q[0];
            @(negedge clk);
            if (it.kind == 1) begin
                int bad = 0;
                for (int i = 0; i < 300; i++) begin
                    if (pwm_out[it.ch] !== it.a[0]) bad++;
                    @(negedge clk);
                end
                check(it.req, bad, 0);
            end else if (it.kind == 2) begin
                while (pwm_out[it.ch] == 1'b1) @(negedge clk);
                lo = 1;
                forever begin @(negedge clk); if (!pwm_out[it.ch]) lo++; else break; end
                check(it.req, lo, it.a);
            end else begin
                while (pwm_out[it.ch] == 1'b1) @(negedge clk);
                while (pwm_out[it.ch] == 1'b0) @(negedge clk);
                hi = 1;
                forever begin @(negedge clk); if (pwm_out[it.ch]) hi++; else break; end
                lo = 1;
                forever begin @(negedge clk); if (!pwm_out[it.ch]) lo++; else break; end
                check(it.req, hi, it.a);
                check(it.req, lo, it.b);
            end
            void'(sb_q.pop_front());
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Driver.
    initial begin
        logic [31:0] d;
        int          n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        check("R1 outputs", {26'd0, pwm_out}, 32'h3F);
        for (int a = 0; a <= 'h34; a += 4) begin
            rd(a, d);
            check("R1 reg zero", d, 0);
        end

        // R2: register map and readback
        wr(8 + 8*3, 32'hFFABCDEF); rd(8 + 8*3, d);  check("R2 period ch3", d, 32'h00ABCDEF);
        wr(12 + 8*5, 32'h00123456); rd(12 + 8*5, d); check("R2 high ch5", d, 32'h00123456);
        wr(4, 32'h00500000);        rd(4, d);        check("R2 divider", d, 32'h00500000);
        wr(0, 32'h01020304);        rd(0, d);        check("R2 control", d, 32'h01020304);
        wr(0, 0); wr(4, 0); wr(8 + 8*3, 0); wr(12 + 8*5, 0);

        // R3: basic waveform, with and without divider
        cfg_ch(0, 0, 10, 4, 1'b1, 1'b0);
        cfg_ch(1, 2, 8, 3, 1'b1, 1'b0);
        settle();
        push("R3 ch0", 0, 0, 4, 6);
        push("R3 ch1 div3", 1, 0, 9, 15);
        drain();

        // R4 polarity, R11 other channel untouched
        cfg_ch(1, 2, 8, 3, 1'b0, 1'b0);
        settle();
        push("R4 ch1 inverted", 1, 0, 15, 9);
        push("R11 ch0 unchanged", 0, 0, 4, 6);
        drain();

        // R5: shadow writes are inert without a trigger rise
        wr(12, 7);
        repeat (30) @(negedge clk);
        push("R5 write with trigger held", 0, 0, 4, 6);
        drain();
        ctrl_v[24] = 1'b1; ctrl_v[0] = 1'b0; wr(0, ctrl_v);
        repeat (30) @(negedge clk);
        push("R5 prepare only", 0, 0, 4, 6);
        drain();
        ctrl_v[24] = 1'b0; ctrl_v[0] = 1'b1; wr(0, ctrl_v);
        settle();
        push("R5 applied after rise", 0, 0, 7, 3);
        drain();

        // R8: both control bits low force a high output
        push("R8 idle ch2", 2, 1, 1, 0);
        drain();
        ctrl_v[0] = 1'b0; ctrl_v[24] = 1'b0; wr(0, ctrl_v);
        repeat (3) @(negedge clk);
        push("R8 ch0 forced", 0, 1, 1, 0);
        drain();

        // R9: zero and over-long high time
        cfg_ch(0, 0, 10, 0, 1'b1, 1'b0);  settle(); push("R9 zero high", 0, 1, 0, 0); drain();
        cfg_ch(0, 0, 10, 12, 1'b1, 1'b0); settle(); push("R9 full high", 0, 1, 1, 0); drain();
        cfg_ch(0, 0, 10, 12, 1'b0, 1'b0); settle(); push("R9 full inverted", 0, 1, 0, 0); drain();

        // R10: period below the minimum
        cfg_ch(0, 0, 1, 1, 1'b1, 1'b0);   settle(); push("R10 period 1", 0, 1, 0, 0); drain();

        // R6: exact immediate-apply latency
        cfg_ch(0, 0, 10, 0, 1'b1, 1'b0);  settle(); push("R6 baseline low", 0, 1, 0, 0); drain();
        cfg_ch(0, 0, 10, 10, 1'b1, 1'b0);
        n = 0;
        forever begin
            @(posedge clk); n++;
            @(negedge clk);
            if (pwm_out[0] || n > 100) break;
        end
        check("R6 latency", n, LAT + 2);

        // R7: smooth transfer waits for the period boundary
        cfg_ch(4, 0, 100, 50, 1'b1, 1'b0);
        settle();
        while (pwm_out[4] == 1'b1) @(negedge clk);
        while (pwm_out[4] == 1'b0) @(negedge clk);
        cfg_ch(4, 0, 20, 5, 1'b1, 1'b1);
        push("R7 old low phase kept", 4, 2, 50, 0);
        push("R7 new period", 4, 0, 5, 15);
        drain();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule